// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers the request lines of a set of devices and folds them into one interrupt request for the processor. Each device has its own programmable priority, vector and mask bit. A device counts as eligible only when all three of these hold: its request is high, it is not masked, and its priority is strictly above the level the processor is currently running at. The processor request is high whenever at least one device is eligible.

When the processor acknowledges, the block picks one eligible device. Under fixed arbitration the lowest index wins. Under round-robin arbitration the search starts just after the device granted last and wraps around, so a busy device cannot starve the others. In the cycle after the acknowledge, the block presents the winner's vector and index and pulses a one-hot acknowledge back to that device so it can drop its request. A small write port loads the per-device tables.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset every priority, vector and mask bit is 0, `vec_o`, `ack_id_o` and `dev_ack_o` are 0, and the round-robin search starts at index 0. With every priority 0, no request can be eligible.
- R2: Device i is eligible when `req_i[i]` is 1, its mask bit is 0 and its priority is strictly greater than `cpu_level_i`. `irq_o` is the combinational OR of all eligible devices. A priority equal to the level is held off.
- R3: A device whose mask bit is 1 takes no part in `irq_o` and cannot win arbitration.
- R4: With `rr_mode_i` = 0, the lowest-indexed eligible device wins.
- R5: With `rr_mode_i` = 1, the winner is the first eligible device found by scanning upward from (last granted index + 1), wrapping from N_SRC-1 to 0.
- R6: On a clock edge where `ack_i` is 1 and a device is eligible, `vec_o` takes the winner's vector and `ack_id_o` takes its index. Both are visible from the next cycle on.
- R7: On that same edge `dev_ack_o` becomes one-hot on the winner. It returns to 0 on the next edge unless another acknowledge is granted.
- R8: An edge with `ack_i` = 1 but no eligible device leaves `vec_o`, `ack_id_o` and the last granted index unchanged, and drives `dev_ack_o` to 0.
- R9: A write with `cfg_we` = 1 updates the entry of device `cfg_addr` selected by `cfg_sel`. Code 0 writes the priority from `cfg_wdata[PRI_W-1:0]`. Code 1 writes the vector from the whole of `cfg_wdata`. Code 2 writes the mask from `cfg_wdata[0]`. Code 3 changes nothing.
- R10: Every granted acknowledge records the winner as the last granted index, in either arbitration mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Device request lines |
| cpu_level_i | input | PRI_W | Current processor priority level |
| rr_mode_i | input | 1 | 1 selects round-robin, 0 selects fixed arbitration |
| ack_i | input | 1 | Processor acknowledge |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 2 | Table field code (0 priority, 1 vector, 2 mask, 3 none) |
| cfg_addr | input | IDX_W | Device index to write |
| cfg_wdata | input | VEC_W | Write data |
| irq_o | output | 1 | Combined request to the processor |
| vec_o | output | VEC_W | Vector of the last acknowledged device |
| ack_id_o | output | IDX_W | Index of the last acknowledged device |
| dev_ack_o | output | N_SRC | One-hot, one-cycle acknowledge to the winner |

## Verification
The bench builds the block with 8 sources, 3-bit priorities, 16-bit vectors and the round-robin variant present. With these values every priority level from 0 to 7 can meet every processor level, so the strict-greater boundary comes up often. Because 8 is a power of two, the round-robin wrap from index 7 back to 0 is reached on an ordinary index increment. Random request patterns, levels, modes and mask changes are mixed with directed cases for reset, the ignored field code, equal priorities and a two-device rotation.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [1:0] {
      CFG_PRIO = 2'd0,
      CFG_VEC  = 2'd1,
      CFG_MASK = 2'd2,
      CFG_NONE = 2'd3
   } cfg_field_e;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
   import intc_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int PRI_W = 3,
   parameter int VEC_W = 16,
   parameter int IDX_W = 3
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  cfg_field_e                    field_i,
   input  logic [IDX_W-1:0]              addr_i,
   input  logic [VEC_W-1:0]              wdata_i,
   output logic [N_SRC-1:0][PRI_W-1:0]   prio_o,
   output logic [N_SRC-1:0][VEC_W-1:0]   vec_o,
   output logic [N_SRC-1:0]              mask_o
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_entry
      logic hit;
      assign hit = we_i && (addr_i == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_o[g] <= '0;
            vec_o[g]  <= '0;
            mask_o[g] <= 1'b0;
         end else if (hit) begin
            case (field_i)
               CFG_PRIO: prio_o[g] <= wdata_i[PRI_W-1:0];
               CFG_VEC:  vec_o[g]  <= wdata_i;
               CFG_MASK: mask_o[g] <= wdata_i[0];
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/intc_gate.sv
module intc_gate #(
   parameter int N_SRC = 8,
   parameter int PRI_W = 3
)(
   input  logic [N_SRC-1:0]              req_i,
   input  logic [N_SRC-1:0]              mask_i,
   input  logic [N_SRC-1:0][PRI_W-1:0]   prio_i,
   input  logic [PRI_W-1:0]              level_i,
   output logic [N_SRC-1:0]              elig_o
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_bit
      assign elig_o[g] = req_i[g] && !mask_i[g] && (prio_i[g] > level_i);
   end
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int N_SRC = 8,
   parameter int IDX_W = 3,
   parameter bit RR_EN = 1'b1
)(
   input  logic [N_SRC-1:0]  elig_i,
   input  logic              rr_mode_i,
   input  logic [IDX_W-1:0]  last_i,
   output logic              any_o,
   output logic [IDX_W-1:0]  win_o
);
   logic [IDX_W-1:0] fixed_win;

   assign any_o = |elig_i;

   always_comb begin
      fixed_win = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig_i[i]) fixed_win = IDX_W'(i);
      end
   end

   if (RR_EN) begin : g_rr
      logic [IDX_W-1:0] rr_win;
      always_comb begin
         int unsigned pos;
         rr_win = '0;
         for (int k = N_SRC; k >= 1; k--) begin
            pos = int'(last_i) + k;
            if (pos >= N_SRC) pos = pos - N_SRC;
            if (elig_i[pos]) rr_win = IDX_W'(pos);
         end
      end
      assign win_o = rr_mode_i ? rr_win : fixed_win;
   end else begin : g_fixed
      logic unused_rr;
      assign unused_rr = rr_mode_i ^ (^last_i);
      assign win_o = fixed_win;
   end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
   import intc_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int PRI_W = 3,
   parameter int VEC_W = 16,
   parameter bit RR_EN = 1'b1,
   localparam int IDX_W = $clog2(N_SRC)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  req_i,
   input  logic [PRI_W-1:0]  cpu_level_i,
   input  logic              rr_mode_i,
   input  logic              ack_i,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [IDX_W-1:0]  cfg_addr,
   input  logic [VEC_W-1:0]  cfg_wdata,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic [IDX_W-1:0]  ack_id_o,
   output logic [N_SRC-1:0]  dev_ack_o
);
   if (N_SRC < 2) begin : g_bad_n
      $error("prio_vec_intc: N_SRC must be at least 2");
   end
   if (PRI_W < 1) begin : g_bad_pri
      $error("prio_vec_intc: PRI_W must be at least 1");
   end
   if (VEC_W < PRI_W) begin : g_bad_vec
      $error("prio_vec_intc: VEC_W must not be narrower than PRI_W");
   end

   logic [N_SRC-1:0][PRI_W-1:0] prio_tab;
   logic [N_SRC-1:0][VEC_W-1:0] vec_tab;
   logic [N_SRC-1:0]            mask_tab;
   logic [N_SRC-1:0]            elig;
   logic                        any_elig;
   logic [IDX_W-1:0]            win;
   logic [IDX_W-1:0]            last_q;
   logic                        grant;

   intc_cfg_regs #(
      .N_SRC(N_SRC), .PRI_W(PRI_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we),
      .field_i (cfg_field_e'(cfg_sel)),
      .addr_i  (cfg_addr),
      .wdata_i (cfg_wdata),
      .prio_o  (prio_tab),
      .vec_o   (vec_tab),
      .mask_o  (mask_tab)
   );

   intc_gate #(
      .N_SRC(N_SRC), .PRI_W(PRI_W)
   ) u_gate (
      .req_i   (req_i),
      .mask_i  (mask_tab),
      .prio_i  (prio_tab),
      .level_i (cpu_level_i),
      .elig_o  (elig)
   );

   intc_arbiter #(
      .N_SRC(N_SRC), .IDX_W(IDX_W), .RR_EN(RR_EN)
   ) u_arb (
      .elig_i    (elig),
      .rr_mode_i (rr_mode_i),
      .last_i    (last_q),
      .any_o     (any_elig),
      .win_o     (win)
   );

   assign irq_o = any_elig;
   assign grant = ack_i && any_elig;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o     <= '0;
         ack_id_o  <= '0;
         dev_ack_o <= '0;
         last_q    <= IDX_W'(N_SRC - 1);
      end else begin
         dev_ack_o <= '0;
         if (grant) begin
            vec_o          <= vec_tab[win];
            ack_id_o       <= win;
            dev_ack_o[win] <= 1'b1;
            last_q         <= win;
         end
      end
   end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int N_SRC = 8,
   parameter int VEC_W = 16,
   parameter int IDX_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  req_i,
   input logic              ack_i,
   input logic              irq_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic [IDX_W-1:0]  ack_id_o,
   input logic [N_SRC-1:0]  dev_ack_o
);
   // R2
   no_req_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i == '0) |-> !irq_o);

   // R7
   ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_ack_o));

   // R7
   ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_ack_o != '0) && !ack_i) |=> (dev_ack_o == '0));

   // R6
   ack_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> ($countones(dev_ack_o) == 1));

   // R6
   ack_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_ack_o != '0) |-> dev_ack_o[ack_id_o]);

   // R8
   idle_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ack_i && irq_o)) |=> ($stable(vec_o) && $stable(ack_id_o) && (dev_ack_o == '0)));
endmodule

bind prio_vec_intc intc_chk #(
   .N_SRC(N_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .ack_i     (ack_i),
   .irq_o     (irq_o),
   .vec_o     (vec_o),
   .ack_id_o  (ack_id_o),
   .dev_ack_o (dev_ack_o)
);

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
   localparam int N = 8;
   localparam int PW = 3;
   localparam int VW = 16;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_i = '0;
   logic [PW-1:0] cpu_level_i = '0;
   logic          rr_mode_i = 1'b0;
   logic          ack_i = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [IW-1:0] cfg_addr = '0;
   logic [VW-1:0] cfg_wdata = '0;
   logic          irq_o;
   logic [VW-1:0] vec_o;
   logic [IW-1:0] ack_id_o;
   logic [N-1:0]  dev_ack_o;

   prio_vec_intc #(.N_SRC(N), .PRI_W(PW), .VEC_W(VW), .RR_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .cpu_level_i(cpu_level_i),
      .rr_mode_i(rr_mode_i), .ack_i(ack_i), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_o(irq_o), .vec_o(vec_o),
      .ack_id_o(ack_id_o), .dev_ack_o(dev_ack_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;

   logic [PW-1:0] m_prio [N];
   logic [VW-1:0] m_vec  [N];
   logic          m_mask [N];
   int            m_last = N - 1;
   logic [VW-1:0] e_vec = '0;
   logic [IW-1:0] e_id  = '0;
   logic [N-1:0]  e_ack = '0;
   string         e_tag = "R1";

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] m_elig();
      logic [N-1:0] e;
      for (int i = 0; i < N; i++)
         e[i] = req_i[i] && !m_mask[i] && (m_prio[i] > cpu_level_i);
      return e;
   endfunction

   function automatic int m_pick(input logic [N-1:0] e, input logic rr, input int last);
      if (!rr) begin
         for (int i = 0; i < N; i++) if (e[i]) return i;
      end else begin
         for (int k = 1; k <= N; k++) if (e[(last + k) % N]) return (last + k) % N;
      end
      return 0;
   endfunction

   task automatic check_regs();
      chk(dev_ack_o == e_ack, {e_tag, " dev_ack R7"}, 32'(dev_ack_o), 32'(e_ack));
      chk(vec_o == e_vec, {e_tag, " vec R6"}, 32'(vec_o), 32'(e_vec));
      chk(ack_id_o == e_id, {e_tag, " id R6"}, 32'(ack_id_o), 32'(e_id));
   endtask

   task automatic step(input logic [N-1:0] rq, input logic [PW-1:0] lvl,
                       input logic rr, input logic ak, input string tag);
      logic [N-1:0] e;
      int w;
      @(negedge clk);
      check_regs();
      req_i = rq; cpu_level_i = lvl; rr_mode_i = rr; ack_i = ak; cfg_we = 1'b0;
      #1;
      e = m_elig();
      chk(irq_o == (|e), {tag, " irq R2/R3"}, 32'(irq_o), 32'(|e));
      if (ak && (|e)) begin
         w = m_pick(e, rr, m_last);
         e_vec = m_vec[w]; e_id = IW'(w); e_ack = N'(1) << w; m_last = w;
         e_tag = rr ? "R5/R10" : "R4/R10";
      end else begin
         e_ack = '0;
         e_tag = ak ? "R8" : "R7";
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input int addr, input logic [VW-1:0] d);
      @(negedge clk);
      check_regs();
      ack_i = 1'b0; cfg_we = 1'b1; cfg_sel = sel; cfg_addr = IW'(addr); cfg_wdata = d;
      e_ack = '0; e_tag = "R9";
      case (sel)
         2'd0: m_prio[addr] = d[PW-1:0];
         2'd1: m_vec[addr]  = d;
         2'd2: m_mask[addr] = d[0];
         default: ;
      endcase
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1a7e));
      for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_vec[i] = '0; m_mask[i] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(dev_ack_o == '0, "R1 dev_ack", 32'(dev_ack_o), 0);
      chk(vec_o == '0, "R1 vec", 32'(vec_o), 0);
      chk(ack_id_o == '0, "R1 id", 32'(ack_id_o), 0);
      // R1 priorities reset to 0: nothing eligible
      step(8'hff, 3'd0, 1'b0, 1'b1, "R1");
      // R9 field code 3 writes nothing
      cfg(2'd3, 0, 16'h0007);
      step(8'h01, 3'd0, 1'b0, 1'b0, "R9");
      // R2 strict comparison
      cfg(2'd0, 0, 16'h0005);
      cfg(2'd1, 0, 16'haaaa);
      step(8'h01, 3'd4, 1'b0, 1'b0, "R2");
      step(8'h01, 3'd5, 1'b0, 1'b1, "R2");
      step(8'h01, 3'd4, 1'b0, 1'b1, "R6");
      // R3 mask
      cfg(2'd2, 0, 16'h0001);
      step(8'h01, 3'd0, 1'b0, 1'b1, "R3");
      cfg(2'd2, 0, 16'h0000);
      // R5 rotation between two devices with equal priority
      for (int i = 0; i < N; i++) begin
         cfg(2'd0, i, 16'h0007);
         cfg(2'd1, i, VW'($urandom));
      end
      for (int i = 0; i < 6; i++) step(8'h81, 3'd0, 1'b1, 1'b1, "R5");
      // R4 fixed mode keeps choosing index 0
      for (int i = 0; i < 3; i++) step(8'h81, 3'd0, 1'b0, 1'b1, "R4");
      // random mixture
      for (int it = 0; it < 4000; it++) begin
         if ($urandom_range(0, 19) == 0) begin
            cfg(2'($urandom_range(0, 3)), $urandom_range(0, N - 1),
                VW'($urandom_range(0, 3) == 0 ? $urandom_range(0, 1) : $urandom));
         end else begin
            step(N'($urandom), PW'($urandom_range(0, 5)), 1'($urandom),
                 1'($urandom), "rand");
         end
      end
      step('0, 3'd0, 1'b0, 1'b0, "R8");
      step('0, 3'd0, 1'b0, 1'b0, "R7");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule